// File: doc/BRIEF.md
# DDS Command Word Register Decoder

This block sits behind a serial front end in a direct digital synthesis datapath. Each cycle it may receive one complete 16-bit command word, marked by a single-cycle valid strobe. The two top bits of the word pick where the word goes: a control register, one of two 28-bit tuning (frequency) registers, or one of two 12-bit phase offset registers. The register contents are driven straight out to the accumulator and phase logic that sit downstream.

A tuning register can be written in one of two ways, and a control bit picks the way. In full-word mode, two writes in a row to the same tuning register build one 28-bit value: the first write gives the low 14 bits and the second gives the high 14 bits. The first half waits in a private staging register. The whole value appears at the output in one step, so downstream logic never sees a half-written tuning word. In split mode, each write replaces only the low half or only the high half, and a second control bit picks which half.

Top module: `dds_cmd_decoder`

## Requirements
- R1: Word bits [15:14] pick the destination: 2'b00 control, 2'b01 tuning register 0, 2'b10 tuning register 1, 2'b11 phase register. At most one destination is written per accepted word.
- R2: A control write stores word bits [13:0] on `ctrl_bits`. Bit 13 set selects full-word tuning mode. Bit 12 is the half select used in split mode.
- R3: In full-word mode, the first write to a tuning register stages bits [13:0] and leaves that register's output unchanged. The next write to the same register sets the output to {new bits [13:0], staged bits} in a single update.
- R4: In split mode (control bit 13 = 0), a tuning write with control bit 12 = 0 replaces only bits [13:0] of the selected register. With control bit 12 = 1 it replaces only bits [27:14].
- R5: A phase write stores bits [11:0] into phase register 0 when bit 13 = 0, or into phase register 1 when bit 13 = 1. Bit 12 has no effect, and the other phase register keeps its value.
- R6: Each tuning register tracks its own first/second write state. A write to the other tuning register in between does not disturb a pending two-write sequence.
- R7: A control write returns both tuning registers to the first-write state, so the next tuning write after it is treated as a low half that gets staged.
- R8: While `cmd_valid` is low, no output changes, whatever value `cmd_word` holds.
- R9: A synchronous reset sets every output, staging register and write tracker to zero.
- R10: A write becomes visible at the outputs right after the clock edge that samples it, and not before.
- R11: Starting from reset, the words 0x2000, 0x4000 and 0x7FFF leave tuning register 0 at 0xFFFC000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 16 | Assembled command word |
| ctrl_bits | output | 14 | Current control register contents |
| tune0 | output | 28 | Tuning register 0 |
| tune1 | output | 28 | Tuning register 1 |
| phase0 | output | 12 | Phase offset register 0 |
| phase1 | output | 12 | Phase offset register 1 |

## Verification
The write trackers and the staging registers are not visible at the ports. A wrong tracker bit therefore shows up only one write later, when a tuning write either commits early with a stale low half or holds back the value it should have committed. The vectors run paired writes interleaved across both tuning registers, and cut a pending sequence with a control write, so that each such fault changes a tuning output in the cycle right after the next write. A mis-routed destination or a wrong half select corrupts a register output on the very next cycle, and the bench compares all five outputs after every word.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;

    typedef enum logic [1:0] {
        DEST_CTRL  = 2'b00,
        DEST_TUNE0 = 2'b01,
        DEST_TUNE1 = 2'b10,
        DEST_PHASE = 2'b11
    } dest_e;

    localparam int NUM_TUNE  = 2;
    localparam int NUM_PHASE = 2;

endpackage

// File: rtl/dds_cmd_route.sv
module dds_cmd_route
    import dds_cmd_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic                 cmd_valid,
    input  logic [CMD_W-1:0]     cmd_word,
    output logic                 ctrl_we,
    output logic [NUM_TUNE-1:0]  tune_we,
    output logic [NUM_PHASE-1:0] phase_we
);
    localparam int SEL_BIT = CMD_W - 3;

    dest_e dest;

    always_comb begin
        dest     = dest_e'(cmd_word[CMD_W-1 -: 2]);
        ctrl_we  = 1'b0;
        tune_we  = '0;
        phase_we = '0;
        if (cmd_valid) begin
            unique case (dest)
                DEST_CTRL:  ctrl_we    = 1'b1;
                DEST_TUNE0: tune_we[0] = 1'b1;
                DEST_TUNE1: tune_we[1] = 1'b1;
                DEST_PHASE: phase_we[cmd_word[SEL_BIT]] = 1'b1;
                default:    ctrl_we    = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dds_tune_slot.sv
module dds_tune_slot #(
    parameter int HALF_W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                clr_seq,
    input  logic                full_mode,
    input  logic                hi_half,
    input  logic [HALF_W-1:0]   payload,
    output logic [2*HALF_W-1:0] value
);
    localparam int TUNE_W = 2 * HALF_W;

    typedef struct packed {
        logic              second;
        logic [HALF_W-1:0] stage;
        logic [TUNE_W-1:0] value;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_seq) begin
            s_d.second = 1'b0;
        end else if (wr_en) begin
            if (full_mode) begin
                if (s_q.second) begin
                    s_d.value  = {payload, s_q.stage};
                    s_d.second = 1'b0;
                end else begin
                    s_d.stage  = payload;
                    s_d.second = 1'b1;
                end
            end else if (hi_half) begin
                s_d.value[TUNE_W-1:HALF_W] = payload;
            end else begin
                s_d.value[HALF_W-1:0] = payload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign value = s_q.value;

    // R3: the second write commits the staged low half and the new high half together
    p_full_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_seq && full_mode && s_q.second)
        |=> (value == {$past(payload), $past(s_q.stage)}));

    // R3: the first write leaves the visible value untouched
    p_stage_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_seq && full_mode && !s_q.second) |=> $stable(value));

    p_split_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_seq && !full_mode && !hi_half)
        |=> (value[HALF_W-1:0] == $past(payload))
            && $stable(value[TUNE_W-1:HALF_W]));

    p_split_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_seq && !full_mode && hi_half)
        |=> (value[TUNE_W-1:HALF_W] == $past(payload))
            && $stable(value[HALF_W-1:0]));

    p_seq_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_seq |=> !s_q.second);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(value));

endmodule

// File: rtl/dds_cmd_decoder.sv
module dds_cmd_decoder
    import dds_cmd_pkg::*;
#(
    parameter int HALF_W  = 14,
    parameter int PHASE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [HALF_W+1:0]   cmd_word,
    output logic [HALF_W-1:0]   ctrl_bits,
    output logic [2*HALF_W-1:0] tune0,
    output logic [2*HALF_W-1:0] tune1,
    output logic [PHASE_W-1:0]  phase0,
    output logic [PHASE_W-1:0]  phase1
);
    localparam int CMD_W    = HALF_W + 2;
    localparam int TUNE_W   = 2 * HALF_W;
    localparam int FULL_BIT = HALF_W - 1;
    localparam int HI_BIT   = HALF_W - 2;

    typedef struct packed {
        logic [HALF_W-1:0]                 ctrl;
        logic [NUM_PHASE-1:0][PHASE_W-1:0] phase;
    } regs_t;

    regs_t r_d, r_q;

    logic                 ctrl_we;
    logic [NUM_TUNE-1:0]  tune_we;
    logic [NUM_PHASE-1:0] phase_we;
    logic [TUNE_W-1:0]    tune_val [NUM_TUNE];

    dds_cmd_route #(.CMD_W(CMD_W)) u_route (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .ctrl_we   (ctrl_we),
        .tune_we   (tune_we),
        .phase_we  (phase_we)
    );

    for (genvar k = 0; k < NUM_TUNE; k++) begin : g_tune
        dds_tune_slot #(.HALF_W(HALF_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (tune_we[k]),
            .clr_seq   (ctrl_we),
            .full_mode (r_q.ctrl[FULL_BIT]),
            .hi_half   (r_q.ctrl[HI_BIT]),
            .payload   (cmd_word[HALF_W-1:0]),
            .value     (tune_val[k])
        );
    end

    always_comb begin
        r_d = r_q;
        if (ctrl_we) r_d.ctrl = cmd_word[HALF_W-1:0];
        for (int p = 0; p < NUM_PHASE; p++) begin
            if (phase_we[p]) r_d.phase[p] = cmd_word[PHASE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign ctrl_bits = r_q.ctrl;
    assign tune0     = tune_val[0];
    assign tune1     = tune_val[1];
    assign phase0    = r_q.phase[0];
    assign phase1    = r_q.phase[1];

    p_route_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_we, tune_we, phase_we}));

    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_word[CMD_W-1 -: 2] == 2'b00)
        |=> (ctrl_bits == $past(cmd_word[HALF_W-1:0])));

    p_phase_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_word[CMD_W-1 -: 2] == 2'b11 && !cmd_word[CMD_W-3])
        |=> (phase0 == $past(cmd_word[PHASE_W-1:0])) && $stable(phase1));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(ctrl_bits) && $stable(phase0) && $stable(phase1)
                       && $stable(tune0) && $stable(tune1));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (ctrl_bits == '0) && (tune0 == '0) && (tune1 == '0)
                && (phase0 == '0) && (phase1 == '0));

endmodule

// File: tb/dds_cmd_decoder_bench.sv
module dds_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic [13:0] ctrl_bits;
    logic [27:0] tune0, tune1;
    logic [11:0] phase0, phase1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dds_cmd_decoder u_dds_cmd_decoder (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .ctrl_bits (ctrl_bits),
        .tune0     (tune0),
        .tune1     (tune1),
        .phase0    (phase0),
        .phase1    (phase1)
    );

    // {req, word, ctrl, tune0, tune1, phase0, phase1} = 4+16+14+28+28+12+12 = 114 bits
    localparam int NV = 18;
    localparam logic [113:0] VEC [NV] = '{
        {4'd2,  16'h2000, 14'h2000, 28'h0000000, 28'h0000000, 12'h000, 12'h000}, // R2 full mode on
        {4'd3,  16'h4000, 14'h2000, 28'h0000000, 28'h0000000, 12'h000, 12'h000}, // R3 staged, no change
        {4'd11, 16'h7FFF, 14'h2000, 28'hFFFC000, 28'h0000000, 12'h000, 12'h000}, // R11 commit
        {4'd3,  16'h8123, 14'h2000, 28'hFFFC000, 28'h0000000, 12'h000, 12'h000}, // R3 tune1 staged
        {4'd6,  16'h4555, 14'h2000, 28'hFFFC000, 28'h0000000, 12'h000, 12'h000}, // R6 tune0 staged
        {4'd6,  16'hBFFF, 14'h2000, 28'hFFFC000, 28'hFFFC123, 12'h000, 12'h000}, // R6 tune1 commit
        {4'd6,  16'h6AAA, 14'h2000, 28'hAAA8555, 28'hFFFC123, 12'h000, 12'h000}, // R6 tune0 commit
        {4'd3,  16'h4111, 14'h2000, 28'hAAA8555, 28'hFFFC123, 12'h000, 12'h000}, // R3 pending
        {4'd7,  16'h2000, 14'h2000, 28'hAAA8555, 28'hFFFC123, 12'h000, 12'h000}, // R7 ctrl clears
        {4'd7,  16'h4222, 14'h2000, 28'hAAA8555, 28'hFFFC123, 12'h000, 12'h000}, // R7 first again
        {4'd7,  16'h4333, 14'h2000, 28'h0CCC222, 28'hFFFC123, 12'h000, 12'h000}, // R7 commit
        {4'd2,  16'h0000, 14'h0000, 28'h0CCC222, 28'hFFFC123, 12'h000, 12'h000}, // R2 split, low
        {4'd4,  16'hBFFF, 14'h0000, 28'h0CCC222, 28'hFFFFFFF, 12'h000, 12'h000}, // R4 low half
        {4'd2,  16'h1000, 14'h1000, 28'h0CCC222, 28'hFFFFFFF, 12'h000, 12'h000}, // R2 split, high
        {4'd4,  16'h40FF, 14'h1000, 28'h03FC222, 28'hFFFFFFF, 12'h000, 12'h000}, // R4 high half
        {4'd1,  16'hC7AB, 14'h1000, 28'h03FC222, 28'hFFFFFFF, 12'h7AB, 12'h000}, // R1 phase dest
        {4'd5,  16'hF456, 14'h1000, 28'h03FC222, 28'hFFFFFFF, 12'h7AB, 12'h456}, // R5 sel 1
        {4'd5,  16'hD001, 14'h1000, 28'h03FC222, 28'hFFFFFFF, 12'h001, 12'h456}  // R5 bit12 ignored
    };

    task automatic check(input int req, input string what,
                         input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [13:0] c, input logic [27:0] f0,
                             input logic [27:0] f1, input logic [11:0] p0,
                             input logic [11:0] p1);
        check(req, "ctrl_bits", {14'd0, ctrl_bits}, {14'd0, c});
        check(req, "tune0", tune0, f0);
        check(req, "tune1", tune1, f1);
        check(req, "phase0", {16'd0, phase0}, {16'd0, p0});
        check(req, "phase1", {16'd0, phase1}, {16'd0, p1});
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_word  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check_all(9, 14'h0, 28'h0, 28'h0, 12'h0, 12'h0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][109:94]);
            check_all(int'(VEC[i][113:110]), VEC[i][93:80], VEC[i][79:52],
                      VEC[i][51:24], VEC[i][23:12], VEC[i][11:0]);
        end

        // R8: word present but strobe low, nothing moves
        @(negedge clk);
        cmd_word  = 16'h4FFF;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        cmd_word = 16'h0000;
        repeat (2) @(negedge clk);
        check_all(8, 14'h1000, 28'h03FC222, 28'hFFFFFFF, 12'h001, 12'h456);

        // R10: no change before the sampling edge, change right after it
        @(negedge clk);
        cmd_word  = 16'hCABC;
        cmd_valid = 1'b1;
        #1;
        check(10, "phase0 before edge", {16'd0, phase0}, {16'd0, 12'h001});
        @(negedge clk);
        cmd_valid = 1'b0;
        check(10, "phase0 after edge", {16'd0, phase0}, {16'd0, 12'hABC});

        // R3: staged half survives an idle gap, then commits
        send(16'h2000);
        send(16'h8001);
        repeat (4) @(negedge clk);
        check(3, "tune1 held while staged", tune1, 28'hFFFFFFF);
        send(16'h8002);
        check(3, "tune1 commit after gap", tune1, 28'h0008001);

        // R9: mid-run reset clears everything, including a pending stage
        send(16'h4123);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_all(9, 14'h0, 28'h0, 28'h0, 12'h0, 12'h0);
        // after reset the mode is split/low, so one write sets the low half directly
        send(16'h4005);
        check(9, "tune0 after reset", tune0, 28'h0000005);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule